// File: doc/BRIEF.md
# Tracking Position Counter with Range Flags

This block is the digital end of a Type II tracking loop for a linear displacement sensor. An oscillator outside the block issues step pulses together with a direction level. Each step moves a 14-bit position count by one least significant bit, and an output pulse reports every change that actually takes place. The analog chain that makes the steps (demodulator, integrator, oscillator) lies outside this block. Here, step and direction arrive as plain single-cycle enables in the system clock domain.

The count space is split into four equal quarters. The two middle quarters, on each side of the mid-scale zero point, form the linear measuring range. The lowest quarter raises an under-range flag and the highest raises an over-range flag. From the count the block also decodes three outputs: a null flag for zero displacement, a sign level, and a 13-bit offset-binary displacement word. The word is clamped at its rails when the count leaves the linear range. The count saturates at both ends of its space and does not wrap.

Top module: `trk_counter_top`

## Requirements
- R1: A synchronous reset sets the count to mid-scale 0x2000. With the count at mid-scale the outputs read null=1, sign=0, over=0, under=0, disp=0x1000, and the update pulse is 0.
- R2: A step with dir=1 raises the count by exactly one, unless it is at 0x3FFF. The update pulse is high in the same cycle that the new count appears.
- R3: A step with dir=0 lowers the count by exactly one, unless it is at 0x0000. The update pulse is high in the same cycle that the new count appears.
- R4: In a cycle without a step, the count holds, and the update pulse is low in the cycle that follows.
- R5: At 0x3FFF, an upward step leaves the count at 0x3FFF and emits no update pulse.
- R6: At 0x0000, a downward step leaves the count at 0x0000 and emits no update pulse.
- R7: The over-range flag is high exactly when count >= 0x3000. While it is high, disp reads 0x1FFF.
- R8: The under-range flag is high exactly when count < 0x1000. While it is high, disp reads 0x0000.
- R9: For a count in 0x1000..0x2FFF, disp equals count - 0x1000. This is offset binary, with 0x1000 as zero displacement.
- R10: The sign output is 0 when count >= 0x2000 (zero or in-phase displacement) and 1 below that.
- R11: The null flag is high exactly when count equals 0x2000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset to mid-scale, active high |
| step_i | input | 1 | One-cycle step enable from the loop oscillator |
| dir_i | input | 1 | Step direction, 1 = up, 0 = down |
| count_o | output | 14 | Position count |
| disp_o | output | 13 | Offset-binary displacement, clamped outside the linear range |
| sign_o | output | 1 | 0 for zero or in-phase displacement |
| over_o | output | 1 | Over-range flag |
| under_o | output | 1 | Under-range flag |
| null_o | output | 1 | Zero-displacement flag |
| step_o | output | 1 | One-cycle pulse for each one-LSB count change |

## Verification
The hardest states to reach are the two saturation rails. A single step moves the count by only one, so 0x3FFF lies 8191 steps above reset and 0x0000 lies 16383 steps below the top rail. The stimulus holds the step enable high for long continuous trains and checks each boundary on the way: the over-range and under-range thresholds and both halves of the zero crossing. Extra steps are then pressed against each rail to show that the count stays put and no update pulse appears.

// File: rtl/trk_pkg.sv
package trk_pkg;
  typedef enum logic [1:0] {
    RNG_UNDER  = 2'd0,
    RNG_LINEAR = 2'd1,
    RNG_OVER   = 2'd2
  } range_t;
endpackage

// File: rtl/trk_step_counter.sv
module trk_step_counter #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         dir,
  output logic [W-1:0] count,
  output logic         moved
);
  localparam logic [W-1:0] TOP  = '1;
  localparam logic [W-1:0] BOT  = '0;
  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] MIDV = W'(1) << (W - 1);

  logic can_up, can_dn;
  assign can_up = (count != TOP);
  assign can_dn = (count != BOT);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= MIDV;
      moved <= 1'b0;
    end else begin
      moved <= 1'b0;
      if (step) begin
        if (dir && can_up) begin
          count <= count + ONE;
          moved <= 1'b1;
        end else if (!dir && can_dn) begin
          count <= count - ONE;
          moved <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/trk_range_decode.sv
module trk_range_decode
  import trk_pkg::*;
#(
  parameter int W = 14
) (
  input  logic [W-1:0] count,
  output logic [W-2:0] disp,
  output logic         sign,
  output logic         over,
  output logic         under,
  output logic         nul
);
  localparam logic [W-1:0] QTR   = W'(1) << (W - 2);
  localparam logic [W-1:0] MIDV  = W'(1) << (W - 1);
  localparam logic [W-1:0] HI_TH = MIDV + QTR;

  range_t       rng;
  logic [W-1:0] offs;

  always_comb begin
    if (count < QTR)         rng = RNG_UNDER;
    else if (count >= HI_TH) rng = RNG_OVER;
    else                     rng = RNG_LINEAR;
  end

  assign offs = count - QTR;

  always_comb begin
    unique case (rng)
      RNG_UNDER: disp = '0;
      RNG_OVER:  disp = '1;
      default:   disp = offs[W-2:0];
    endcase
  end

  assign over  = (rng == RNG_OVER);
  assign under = (rng == RNG_UNDER);
  assign sign  = ~count[W-1];
  assign nul   = (count == MIDV);
endmodule

// File: rtl/trk_counter_top.sv
module trk_counter_top #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step_i,
  input  logic         dir_i,
  output logic [W-1:0] count_o,
  output logic [W-2:0] disp_o,
  output logic         sign_o,
  output logic         over_o,
  output logic         under_o,
  output logic         null_o,
  output logic         step_o
);
  logic [W-1:0] cnt;

  trk_step_counter #(.W(W)) i_cnt (
    .clk   (clk),
    .rst   (rst),
    .step  (step_i),
    .dir   (dir_i),
    .count (cnt),
    .moved (step_o)
  );

  trk_range_decode #(.W(W)) i_dec (
    .count (cnt),
    .disp  (disp_o),
    .sign  (sign_o),
    .over  (over_o),
    .under (under_o),
    .nul   (null_o)
  );

  assign count_o = cnt;
endmodule

// File: rtl/trk_counter_chk.sv
module trk_counter_chk #(
  parameter int W = 14
) (
  input logic         clk,
  input logic         rst,
  input logic         step_i,
  input logic         dir_i,
  input logic [W-1:0] count_o,
  input logic [W-2:0] disp_o,
  input logic         over_o,
  input logic         under_o,
  input logic         null_o,
  input logic         step_o
);
  localparam logic [W-1:0] TOP  = '1;
  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-2:0] DZERO = (W-1)'(1) << (W - 2);

  a_r2_up_step: assert property (@(posedge clk) disable iff (rst)
    (step_i && dir_i && count_o != TOP) |=> (count_o == $past(count_o) + ONE) && step_o);

  a_r3_down_step: assert property (@(posedge clk) disable iff (rst)
    (step_i && !dir_i && count_o != '0) |=> (count_o == $past(count_o) - ONE) && step_o);

  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> $stable(count_o) && !step_o);

  a_r5_top_rail: assert property (@(posedge clk) disable iff (rst)
    (step_i && dir_i && count_o == TOP) |=> (count_o == TOP) && !step_o);

  a_r6_bottom_rail: assert property (@(posedge clk) disable iff (rst)
    (step_i && !dir_i && count_o == '0) |=> (count_o == '0) && !step_o);

  a_r7_over_clamp: assert property (@(posedge clk) disable iff (rst)
    over_o |-> (disp_o == '1) && !under_o);

  a_r8_under_clamp: assert property (@(posedge clk) disable iff (rst)
    under_o |-> (disp_o == '0) && !over_o);

  a_r11_null_code: assert property (@(posedge clk) disable iff (rst)
    null_o |-> (disp_o == DZERO) && !over_o && !under_o);
endmodule

bind trk_counter_top trk_counter_chk #(.W(W)) i_chk (
  .clk     (clk),
  .rst     (rst),
  .step_i  (step_i),
  .dir_i   (dir_i),
  .count_o (count_o),
  .disp_o  (disp_o),
  .over_o  (over_o),
  .under_o (under_o),
  .null_o  (null_o),
  .step_o  (step_o)
);

// File: tb/test_trk_counter_top.sv
module test_trk_counter_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        step_i = 1'b0;
  logic        dir_i = 1'b0;
  logic [13:0] count_o;
  logic [12:0] disp_o;
  logic        sign_o, over_o, under_o, null_o, step_o;

  int n_run  = 0;
  int n_fail = 0;
  int model  = 0;

  always #10 clk = ~clk;

  trk_counter_top i_trk_counter_top (
    .clk(clk), .rst(rst), .step_i(step_i), .dir_i(dir_i),
    .count_o(count_o), .disp_o(disp_o), .sign_o(sign_o),
    .over_o(over_o), .under_o(under_o), .null_o(null_o), .step_o(step_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_decode(input string tag);
    int e_disp;
    if (model < 32'h1000) e_disp = 0;
    else if (model >= 32'h3000) e_disp = 32'h1FFF;
    else e_disp = model - 32'h1000;
    chk({"R9/R7/R8 disp ", tag}, int'(disp_o), e_disp);
    chk({"R7 over ", tag}, int'(over_o), (model >= 32'h3000) ? 1 : 0);
    chk({"R8 under ", tag}, int'(under_o), (model < 32'h1000) ? 1 : 0);
    chk({"R10 sign ", tag}, int'(sign_o), (model >= 32'h2000) ? 0 : 1);
    chk({"R11 null ", tag}, int'(null_o), (model == 32'h2000) ? 1 : 0);
  endtask

  // one step per cycle for n cycles; model saturates per R2/R3/R5/R6
  task automatic run_steps(input int n, input logic d);
    for (int k = 0; k < n; k++) begin
      step_i = 1'b1;
      dir_i  = d;
      if (d && model < 32'h3FFF) model++;
      else if (!d && model > 0) model--;
      @(negedge clk);
    end
    step_i = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model = 32'h2000;
    chk("R1 count", int'(count_o), 32'h2000);
    chk("R1 step_o", int'(step_o), 0);
    chk("R1 disp", int'(disp_o), 32'h1000);
    chk("R1 null", int'(null_o), 1);
    chk("R1 flags", int'({over_o, under_o, sign_o}), 0);
  endtask

  task automatic t_single();
    run_steps(1, 1'b1);
    chk("R2 count up", int'(count_o), 32'h2001);
    chk("R2 pulse", int'(step_o), 1);
    chk_decode("after up");
    @(negedge clk);
    chk("R4 hold count", int'(count_o), 32'h2001);
    chk("R4 no pulse", int'(step_o), 0);
    run_steps(1, 1'b0);
    chk("R3 count down", int'(count_o), 32'h2000);
    chk("R3 pulse", int'(step_o), 1);
    run_steps(1, 1'b0);
    chk("R3 below zero", int'(count_o), 32'h1FFF);
    chk_decode("zero-1");
    dir_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R4 dir alone", int'(count_o), 32'h1FFF);
    chk("R4 dir alone pulse", int'(step_o), 0);
    run_steps(1, 1'b1);
    chk_decode("back to zero");
  endtask

  task automatic t_upper();
    run_steps(32'h0FFF, 1'b1);
    chk("R9 top linear", int'(count_o), 32'h2FFF);
    chk_decode("2FFF");
    run_steps(1, 1'b1);
    chk("R7 threshold", int'(count_o), 32'h3000);
    chk_decode("3000");
    run_steps(32'h0FFF, 1'b1);
    chk("R5 reach top", int'(count_o), 32'h3FFF);
    chk("R2 pulse at top", int'(step_o), 1);
    run_steps(3, 1'b1);
    chk("R5 saturate", int'(count_o), 32'h3FFF);
    chk("R5 no pulse", int'(step_o), 0);
    chk_decode("3FFF");
    run_steps(1, 1'b0);
    chk("R3 leave top", int'(count_o), 32'h3FFE);
  endtask

  task automatic t_lower();
    run_steps(32'h2FFE, 1'b0);
    chk("R9 bottom linear", int'(count_o), 32'h1000);
    chk_decode("1000");
    run_steps(1, 1'b0);
    chk("R8 threshold", int'(count_o), 32'h0FFF);
    chk_decode("0FFF");
    run_steps(32'h0FFF, 1'b0);
    chk("R6 reach bottom", int'(count_o), 0);
    run_steps(4, 1'b0);
    chk("R6 saturate", int'(count_o), 0);
    chk("R6 no pulse", int'(step_o), 0);
    chk_decode("0000");
    run_steps(1, 1'b1);
    chk("R2 leave bottom", int'(count_o), 1);
    chk("R2 pulse", int'(step_o), 1);
  endtask

  task automatic t_rereset();
    run_steps(5, 1'b1);
    rst = 1'b1;
    step_i = 1'b1;
    dir_i = 1'b1;
    @(negedge clk);
    step_i = 1'b0;
    rst = 1'b0;
    model = 32'h2000;
    chk("R1 reset wins", int'(count_o), 32'h2000);
    chk("R1 reset pulse", int'(step_o), 0);
    chk_decode("reset");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_single();
    t_upper();
    t_lower();
    t_rereset();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule